// File: doc/BRIEF.md
# Dual Serial Game-Controller Port

This block gives a processor bus two serial game-controller ports. Each controller presents its eight buttons as a live parallel byte. A bus write to the strobe address records data bit 0 as a strobe level. When that level goes from 1 to 0, the block takes a snapshot of both live button bytes and moves both read positions back to the first button.

After the snapshot, software reads a port address again and again. Each read returns one button in data bit 0, lowest button first, and moves that port's position on by one. Bits 7 and 6 of every port read hold a fixed 0 and 1. Once a port has handed out all eight buttons, further reads return 0 in bit 0 until the next snapshot. The ports sit at 0x4016 (controller 0, also the strobe address) and 0x4017 (controller 1).

Top module: `gcp_serial_ports`

## Requirements
- R1: A write to address 0x4016 stores bus_wdata[0] as the strobe level. Data bits 7..1 have no effect.
- R2: A write to 0x4016 with bit 0 = 0, made while the stored strobe is 1, copies pad0_btn and pad1_btn into the two snapshot registers and sets both read positions to 0, all at the same clock edge.
- R3: A read of 0x4016 serves controller 0 and a read of 0x4017 serves controller 1. bus_addr[0] selects the port.
- R4: rd_data[0] is the snapshot bit indexed by the port's read position, starting at button bit 0 (LSB first).
- R5: Each port read moves only the accessed port's position forward by one. The other port's position is unchanged.
- R6: During a port read, rd_data[7:1] equals 7'b0100000 (bit 6 is 1, bits 7 and 5..1 are 0).
- R7: Once a position reaches 8, rd_data[0] reads 0 and the position stays at 8 on further reads; it does not wrap.
- R8: A strobe write that keeps the level at 1 (1 to 1), a write that keeps it at 0 (0 to 0), and a write to 0x4017 do not change the snapshots or the positions.
- R9: Reset clears the strobe, both snapshots and both positions, so a port read after reset returns 0x40.
- R10: rd_data is 0x00 whenever no read of 0x4016 or 0x4017 is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| pad0_btn | input | 8 | Live buttons of controller 0 |
| pad1_btn | input | 8 | Live buttons of controller 1 |
| rd_data | output | 8 | Read data, valid in the read cycle |

## Verification
The bench uses the strobe write that carries 0xFE. A design that tested the whole byte instead of bit 0 would miss that capture and return stale buttons. It holds the strobe at 1 across several writes and at 0 across several writes while the live pads change. A design that captured on levels instead of the falling edge would pick up the new buttons. It reads past the eighth button many times. A design that wrapped its position would start repeating the snapshot, and one that ran past 8 would index out of range. It interleaves reads of the two ports. A design that shared one position between them, or swapped them on address bit 0, would return the buttons out of order. Random mixes of writes, reads and idle cycles are checked against a reference model in the bench.

// File: rtl/gcp_pkg.sv
package gcp_pkg;

  localparam int GCP_DATA_W = 8;
  localparam int GCP_BTN_W  = 8;

  // fixed upper bits of a port read: bit 6 high, bit 7 low, bits 5..1 low
  localparam logic [GCP_DATA_W-1:1] GCP_RD_FIXED = 7'b0100000;

  function automatic logic [GCP_DATA_W-1:0] gcp_fmt_read(input logic serial_bit);
    return {GCP_RD_FIXED, serial_bit};
  endfunction

  // true when a write leaves the strobe falling from 1 to 0
  function automatic logic gcp_is_fall(input logic old_lvl, input logic new_lvl);
    return old_lvl & ~new_lvl;
  endfunction

endpackage

// File: rtl/gcp_strobe_ctl.sv
module gcp_strobe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_lvl,
  output logic strobe_q,
  output logic capture_evt
);
  import gcp_pkg::*;

  assign capture_evt = wr_hit & gcp_is_fall(strobe_q, wr_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n)      strobe_q <= 1'b0;
    else if (wr_hit) strobe_q <= wr_lvl;
  end
endmodule

// File: rtl/gcp_port_shift.sv
module gcp_port_shift #(
  parameter int BTN_W = 8,
  localparam int PTR_W = $clog2(BTN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             advance,
  input  logic [BTN_W-1:0] live,
  output logic             cur_bit,
  output logic [PTR_W-1:0] ptr,
  output logic [BTN_W-1:0] snap
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(BTN_W);

  function automatic logic pick_bit(input logic [BTN_W-1:0] v, input logic [PTR_W-1:0] p);
    logic r;
    r = 1'b0;
    for (int i = 0; i < BTN_W; i++) begin
      if (p == PTR_W'(i)) r = v[i];
    end
    return r;
  endfunction

  logic at_end;
  assign at_end  = (ptr == PTR_END);
  assign cur_bit = pick_bit(snap, ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap <= '0;
      ptr  <= '0;
    end else if (capture) begin
      snap <= live;
      ptr  <= '0;
    end else if (advance && !at_end) begin
      ptr  <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/gcp_rd_fmt.sv
module gcp_rd_fmt (
  input  logic       rd_hit,
  input  logic       sel,
  input  logic       bit_p0,
  input  logic       bit_p1,
  output logic [7:0] rd_data
);
  import gcp_pkg::*;

  always_comb begin
    rd_data = '0;
    if (rd_hit) rd_data = gcp_fmt_read(sel ? bit_p1 : bit_p0);
  end
endmodule

// File: rtl/gcp_serial_ports.sv
module gcp_serial_ports #(
  parameter int ADDR_W = 16,
  parameter int BTN_W  = gcp_pkg::GCP_BTN_W,
  parameter logic [ADDR_W-1:0] STROBE_ADDR = 16'h4016,
  localparam int PTR_W = $clog2(BTN_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic [BTN_W-1:0]  pad0_btn,
  input  logic [BTN_W-1:0]  pad1_btn,
  output logic [7:0]        rd_data
);
  localparam int NPORT = 2;

  logic strobe_q, capture_evt, wr_hit, rd_hit, port_sel;
  logic [NPORT-1:0] adv_vec, bit_vec;
  logic [BTN_W-1:0] live_arr [NPORT];
  logic [BTN_W-1:0] snap_arr [NPORT];
  logic [PTR_W-1:0] ptr_arr  [NPORT];
  logic [PTR_W-1:0] ptr_p0, ptr_p1;
  logic [BTN_W-1:0] snap_p0, snap_p1;
  logic             obs_unused;

  assign wr_hit   = bus_wr && (bus_addr == STROBE_ADDR);
  assign rd_hit   = bus_rd && (bus_addr[ADDR_W-1:1] == STROBE_ADDR[ADDR_W-1:1]);
  assign port_sel = bus_addr[0];
  assign live_arr[0] = pad0_btn;
  assign live_arr[1] = pad1_btn;

  gcp_strobe_ctl u_strobe (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_lvl(bus_wdata[0]),
    .strobe_q(strobe_q), .capture_evt(capture_evt)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign adv_vec[g] = rd_hit && (port_sel == g[0]);
    gcp_port_shift #(.BTN_W(BTN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .capture(capture_evt), .advance(adv_vec[g]),
      .live(live_arr[g]), .cur_bit(bit_vec[g]), .ptr(ptr_arr[g]), .snap(snap_arr[g])
    );
  end

  gcp_rd_fmt u_fmt (
    .rd_hit(rd_hit), .sel(port_sel), .bit_p0(bit_vec[0]), .bit_p1(bit_vec[1]),
    .rd_data(rd_data)
  );

  // named observation wires for the checker
  assign ptr_p0  = ptr_arr[0];
  assign ptr_p1  = ptr_arr[1];
  assign snap_p0 = snap_arr[0];
  assign snap_p1 = snap_arr[1];
  assign obs_unused = ^{ptr_p0, ptr_p1, snap_p0, snap_p1, bus_wdata[7:1]};
endmodule

// File: rtl/gcp_serial_ports_chk.sv
module gcp_serial_ports_chk #(
  parameter int ADDR_W = 16,
  parameter int BTN_W  = 8,
  parameter int PTR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_hit,
  input logic              rd_hit,
  input logic              port_sel,
  input logic [7:0]        bus_wdata,
  input logic              strobe_q,
  input logic              capture_evt,
  input logic [PTR_W-1:0]  ptr_p0,
  input logic [PTR_W-1:0]  ptr_p1,
  input logic [BTN_W-1:0]  snap_p0,
  input logic [BTN_W-1:0]  snap_p1,
  input logic [BTN_W-1:0]  pad0_btn,
  input logic [BTN_W-1:0]  pad1_btn,
  input logic [7:0]        rd_data
);
  localparam logic [PTR_W-1:0] PEND = PTR_W'(BTN_W);

  a_r1_strobe_level: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> strobe_q == $past(bus_wdata[0]));

  a_r2_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (snap_p0 == $past(pad0_btn)) && (snap_p1 == $past(pad1_btn))
                    && (ptr_p0 == '0) && (ptr_p1 == '0));

  a_r5_p0_read_keeps_p1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !port_sel && !capture_evt) |=> $stable(ptr_p1));

  a_r5_p1_read_keeps_p0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && port_sel && !capture_evt) |=> $stable(ptr_p0));

  a_r6_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> rd_data[7:1] == 7'b0100000);

  a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_p0 <= PEND) && (ptr_p1 <= PEND));

  a_r7_exhausted_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && ((!port_sel && ptr_p0 == PEND) || (port_sel && ptr_p1 == PEND)))
      |-> rd_data[0] == 1'b0);

  a_r8_no_recapture: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_evt |=> $stable(snap_p0) && $stable(snap_p1));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> rd_data == 8'h00);
endmodule

bind gcp_serial_ports gcp_serial_ports_chk #(.ADDR_W(ADDR_W), .BTN_W(BTN_W), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_hit(rd_hit), .port_sel(port_sel),
  .bus_wdata(bus_wdata), .strobe_q(strobe_q), .capture_evt(capture_evt),
  .ptr_p0(ptr_p0), .ptr_p1(ptr_p1), .snap_p0(snap_p0), .snap_p1(snap_p1),
  .pad0_btn(pad0_btn), .pad1_btn(pad1_btn), .rd_data(rd_data)
);

// File: tb/gcp_serial_ports_tb_top.sv
`timescale 1ns/1ps
module gcp_serial_ports_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0, pad0_btn = '0, pad1_btn = '0;
  logic [7:0]  rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic       m_strobe;
  logic [7:0] m_snap [2];
  int         m_pos  [2];

  always #10 clk = ~clk;

  gcp_serial_ports dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .pad0_btn(pad0_btn), .pad1_btn(pad1_btn), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    int p;
    logic b;
    if (a != 16'h4016 && a != 16'h4017) return 8'h00;
    p = (a == 16'h4017) ? 1 : 0;
    b = (m_pos[p] < 8) ? m_snap[p][m_pos[p]] : 1'b0;
    return 8'h40 | {7'b0, b};
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(posedge clk);
    if (a == 16'h4016) begin
      if (m_strobe && !d[0]) begin
        m_snap[0] = pad0_btn; m_snap[1] = pad1_btn;
        m_pos[0] = 0; m_pos[1] = 0;
      end
      m_strobe = d[0];
    end
    #1 bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #2;
    e = exp_read(a);
    check(rd_data, e, tag);
    @(posedge clk);
    if (a == 16'h4016 && m_pos[0] < 8) m_pos[0]++;
    if (a == 16'h4017 && m_pos[1] < 8) m_pos[1]++;
    #1 bus_rd = 1'b0;
  endtask

  task automatic do_idle(input string tag);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 16'h4016;
    #2 check(rd_data, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_strobe = 0; m_snap[0] = 0; m_snap[1] = 0; m_pos[0] = 0; m_pos[1] = 0;
    pad0_btn = 8'hA5; pad1_btn = 8'h3C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state reads as 0x40 on both ports, live pads not seen
    do_read(16'h4016, "R9 reset p0");
    do_read(16'h4017, "R9 reset p1");
    // R10: idle and non-port address
    do_idle("R10 idle");
    do_read(16'h4015, "R10 other addr");

    // R1/R2: strobe 1 then 0xFE (bit0=0) captures
    do_write(16'h4016, 8'h01);
    do_write(16'h4016, 8'hFE);
    // R3/R4: LSB first, each port its own byte
    for (int i = 0; i < 4; i++) do_read(16'h4016, "R4 p0 lsb first");
    // R5: p1 position still at 0 after p0 reads
    for (int i = 0; i < 8; i++) do_read(16'h4017, "R5 p1 independent R3");
    // R7: p1 exhausted, reads saturate at 0
    for (int i = 0; i < 5; i++) do_read(16'h4017, "R7 past end p1");
    for (int i = 0; i < 8; i++) do_read(16'h4016, "R7 p0 tail and past end");

    // R8: writes 0->0 and to 0x4017 with new pads: no recapture
    pad0_btn = 8'hFF; pad1_btn = 8'hFF;
    do_write(16'h4016, 8'h00);
    do_write(16'h4017, 8'h00);
    do_read(16'h4016, "R8 no recapture 0to0");
    // R8: 1->1 (data 0xFF then 0x03) keeps old snapshot
    do_write(16'h4016, 8'hFF);
    do_write(16'h4016, 8'h03);
    do_read(16'h4017, "R8 no recapture 1to1");
    // R1: 0x80 has bit0=0, so this captures 0xFF pads
    do_write(16'h4016, 8'h80);
    do_read(16'h4016, "R1 bit0 only capture");
    do_read(16'h4017, "R2 both ports captured");
    // R6: fixed bits checked on every read above; one with zero button
    pad0_btn = 8'h00;
    do_write(16'h4016, 8'h01);
    do_write(16'h4016, 8'h00);
    do_read(16'h4016, "R6 fixed bits zero button");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if ($urandom_range(0, 3) == 0) begin
        pad0_btn = 8'($urandom); pad1_btn = 8'($urandom);
      end
      case (k)
        0, 1:    do_write(16'h4016, 8'($urandom));
        2:       do_write(16'h4017, 8'($urandom));
        3, 4, 5: do_read(16'h4016, "R4 random p0");
        6, 7:    do_read(16'h4017, "R3 random p1");
        8:       do_idle("R10 random idle");
        default: do_read(16'h4000 | 16'($urandom_range(0, 31)), "R10 random addr");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule